// File: doc/BRIEF.md
# Latched Event Interrupt Collector

This block gathers single-cycle event pulses from a packet-queue manager, a USB engine, a power controller, four asynchronous external interrupt pins and a vector of DMA channel status lines. It holds them in two byte-wide source registers, and each source register has a mask register. Each register drives one interrupt line toward a microcontroller. An interrupt line is high while any latched source bit in its register has its mask bit cleared.

Firmware reaches the block over a small byte bus, with a select, a write flag, a 3-bit address and read and write data. Reading a source register returns the latched bits and empties the register on the following clock edge. An event that arrives in the read cycle is not lost. The DMA status lines are not latched as levels. Only a low-to-high change on a channel whose DMA mask bit is clear sets the DMA summary bit.

Top module: `evt_irq_collector`

## Requirements
- R1: After reset both source registers read 0x00, both mask registers read 0xFF, the DMA mask register reads all ones in its low DMA_CH bits, and both interrupt outputs are low.
- R2: Source register 0 (address 0) holds the external pins in bits 7..4 (pin 3 in bit 7 down to pin 0 in bit 4), the receive-queued event in bit 3, the transmit-queue-drained event in bit 2, the packet-sent event in bit 1 and the DMA summary in bit 0.
- R3: Source register 1 (address 2) latches grp1_evt_i[k] into bit k for k = 0..4 (0 power, 1 receive overrun, 2 allocation done, 3 start of frame, 4 transaction end). Bits 7..5 always read zero.
- R4: A read of a source register returns its latched value in the same cycle and leaves the register at zero from the next edge, unless an event arrives in that cycle.
- R5: Mask bit value 0 enables and 1 masks. irq0_o and irq1_o are the OR of (source AND NOT mask) for registers 0 and 1. Masking never clears a source bit.
- R6: DMA summary bit 0 is set by a rising edge on any dma_stat_i channel whose DMA mask bit (address 4, bit n for channel n) is 0. A channel that stays high does not set the bit again after a clearing read, and an edge on a masked channel has no effect.
- R7: An event arriving in the same cycle as a clearing read of its register is kept, and the next read returns it.
- R8: Each external pin passes through a two-flop synchroniser. A high synchronised level sets its source bit on every cycle, so a pin held high reappears after each clearing read.
- R9: Mask registers are at addresses 1 (register 0), 3 (register 1) and 4 (DMA) and read back what was written. Writes to addresses 0 and 2 have no effect. Reads of addresses 5..7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_irq_i | input | 4 | Asynchronous external interrupt pins |
| rx_queued_i | input | 1 | Pulse: packet placed on the receive queue |
| tx_drained_i | input | 1 | Pulse: a transmit queue became empty |
| tx_sent_i | input | 1 | Pulse: a packet was transmitted |
| grp1_evt_i | input | 5 | Pulses for source register 1 bits 4..0 |
| dma_stat_i | input | DMA_CH | DMA channel status levels |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| irq0_o | output | 1 | Interrupt from source register 0 |
| irq1_o | output | 1 | Interrupt from source register 1 |

## Verification
Two functions can fall in the same cycle: a clearing read of a source register and a new event for that register. The bench provokes this by pulsing the packet-sent event and a pin level during the read strobe. The read value must exclude the new bit, and a second read must show it. The same collision occurs when a pin is held high, because its level re-asserts the bit every cycle. Reads are judged by a scoreboard that queues each expected byte when the read is issued and compares it at the bus when the strobe is sampled.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ADR_SRC0 = 3'd0,
    ADR_MSK0 = 3'd1,
    ADR_SRC1 = 3'd2,
    ADR_MSK1 = 3'd3,
    ADR_DMSK = 3'd4
  } reg_addr_e;

  // any enabled source bit
  function automatic logic any_unmasked(input logic [BYTE_W-1:0] src,
                                        input logic [BYTE_W-1:0] msk);
    return |(src & ~msk);
  endfunction

  // next latched value: clear on read, then merge fresh events
  function automatic logic [BYTE_W-1:0] next_src(input logic [BYTE_W-1:0] cur,
                                                 input logic [BYTE_W-1:0] evt,
                                                 input logic clr);
    return (clr ? '0 : cur) | evt;
  endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dma_rise_det.sv
module dma_rise_det #(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] stat,
  input  logic [CH-1:0] mask,
  output logic          hit
);
  logic [CH-1:0] prev_q;
  logic [CH-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stat;
  end

  assign rise = stat & ~prev_q & ~mask;
  assign hit  = |rise;
endmodule

// File: rtl/src_latch.sv
module src_latch
  import irq_agg_pkg::*;
#(
  parameter int USED = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] evt,
  input  logic              clr,
  input  logic              mask_wr,
  input  logic [BYTE_W-1:0] mask_wdata,
  output logic [BYTE_W-1:0] src_q,
  output logic [BYTE_W-1:0] mask_q,
  output logic              irq
);
  localparam logic [BYTE_W-1:0] USED_M = BYTE_W'((1 << USED) - 1);

  logic [BYTE_W-1:0] evt_used;
  assign evt_used = evt & USED_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '1;
    end else begin
      src_q <= next_src(src_q, evt_used, clr);
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  assign irq = any_unmasked(src_q, mask_q);
endmodule

// File: rtl/evt_irq_collector.sv
module evt_irq_collector
  import irq_agg_pkg::*;
#(
  parameter int DMA_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        pin_irq_i,
  input  logic              rx_queued_i,
  input  logic              tx_drained_i,
  input  logic              tx_sent_i,
  input  logic [4:0]        grp1_evt_i,
  input  logic [DMA_CH-1:0] dma_stat_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int PIN_N = 4;
  localparam int GRP1_N = 5;

  logic rd_stb, wr_stb;
  logic rd_src0, rd_src1, wr_msk0, wr_msk1, wr_dmsk;
  logic [PIN_N-1:0] pin_lvl;
  logic dma_hit;
  logic [DMA_CH-1:0] dma_msk_q;
  logic [BYTE_W-1:0] evt0, evt1;
  logic [BYTE_W-1:0] src0_q, mask0_q, src1_q, mask1_q;

  assign rd_stb  = bus_sel_i & ~bus_wr_i;
  assign wr_stb  = bus_sel_i &  bus_wr_i;
  assign rd_src0 = rd_stb && (bus_addr_i == ADR_SRC0);
  assign rd_src1 = rd_stb && (bus_addr_i == ADR_SRC1);
  assign wr_msk0 = wr_stb && (bus_addr_i == ADR_MSK0);
  assign wr_msk1 = wr_stb && (bus_addr_i == ADR_MSK1);
  assign wr_dmsk = wr_stb && (bus_addr_i == ADR_DMSK);

  irq_sync2 #(.W(PIN_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_irq_i), .q(pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dma_msk_q <= '1;
    else if (wr_dmsk) dma_msk_q <= bus_wdata_i[DMA_CH-1:0];
  end

  dma_rise_det #(.CH(DMA_CH)) u_dma (
    .clk(clk), .rst_n(rst_n), .stat(dma_stat_i), .mask(dma_msk_q), .hit(dma_hit)
  );

  assign evt0 = {pin_lvl, rx_queued_i, tx_drained_i, tx_sent_i, dma_hit};
  assign evt1 = {{(BYTE_W-GRP1_N){1'b0}}, grp1_evt_i};

  src_latch #(.USED(BYTE_W)) u_src0 (
    .clk(clk), .rst_n(rst_n), .evt(evt0), .clr(rd_src0),
    .mask_wr(wr_msk0), .mask_wdata(bus_wdata_i),
    .src_q(src0_q), .mask_q(mask0_q), .irq(irq0_o)
  );

  src_latch #(.USED(GRP1_N)) u_src1 (
    .clk(clk), .rst_n(rst_n), .evt(evt1), .clr(rd_src1),
    .mask_wr(wr_msk1), .mask_wdata(bus_wdata_i),
    .src_q(src1_q), .mask_q(mask1_q), .irq(irq1_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADR_SRC0: bus_rdata_o = src0_q;
      ADR_MSK0: bus_rdata_o = mask0_q;
      ADR_SRC1: bus_rdata_o = src1_q;
      ADR_MSK1: bus_rdata_o = mask1_q;
      ADR_DMSK: bus_rdata_o[DMA_CH-1:0] = dma_msk_q;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_collector_chk.sv
module evt_irq_collector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_src0,
  input logic       rd_src1,
  input logic [7:0] evt0,
  input logic [7:0] evt1,
  input logic [7:0] src0_q,
  input logic [7:0] mask0_q,
  input logic [7:0] src1_q,
  input logic       dma_hit,
  input logic       irq0_o,
  input logic [2:0] bus_addr_i,
  input logic [7:0] bus_rdata_o
);
  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src0 && evt0 == 8'h00) |=> (src0_q == 8'h00));

  // R7
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt0 != 8'h00) |=> ((src0_q & $past(evt0)) == $past(evt0)));

  // R5
  fully_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask0_q == 8'hFF) |-> !irq0_o);

  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == 3'd2) |-> (bus_rdata_o[7:5] == 3'b000));

  // R6
  dma_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_hit |=> src0_q[0]);

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_src1 && evt1 == 8'h00) |=> $stable(src1_q));
endmodule

bind evt_irq_collector evt_irq_collector_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_src0(rd_src0), .rd_src1(rd_src1),
  .evt0(evt0), .evt1(evt1), .src0_q(src0_q), .mask0_q(mask0_q),
  .src1_q(src1_q), .dma_hit(dma_hit), .irq0_o(irq0_o),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o)
);

// File: tb/evt_irq_collector_tb_top.sv
`timescale 1ns/1ps
module evt_irq_collector_tb_top;
  localparam int DMA_CH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pin_irq = '0;
  logic rx_queued = 0, tx_drained = 0, tx_sent = 0;
  logic [4:0] grp1 = '0;
  logic [DMA_CH-1:0] dma_stat = '0;
  logic sel = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq0, irq1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  evt_irq_collector #(.DMA_CH(DMA_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_irq_i(pin_irq),
    .rx_queued_i(rx_queued), .tx_drained_i(tx_drained), .tx_sent_i(tx_sent),
    .grp1_evt_i(grp1), .dma_stat_i(dma_stat),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq0_o(irq0), .irq1_o(irq1)
  );

  // monitor: compares each read strobe against the scoreboard
  always @(negedge clk) begin
    #5;
    if (sel && !wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read addr=%0d actual=%02h expected=none", addr, rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, addr, rdata, e);
        end
      end
    end
  end

  task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic pulse0(input logic rxq, input logic txd, input logic txs);
    @(negedge clk);
    rx_queued = rxq; tx_drained = txd; tx_sent = txs;
    @(negedge clk);
    rx_queued = 0; tx_drained = 0; tx_sent = 0;
  endtask

  task automatic pulse1(input logic [4:0] v);
    @(negedge clk);
    grp1 = v;
    @(negedge clk);
    grp1 = '0;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk); #5;
    chk_bit(irq0, 1'b0, "R1 irq0 after reset");
    chk_bit(irq1, 1'b0, "R1 irq1 after reset");
    bus_read(3'd0, 8'h00, "R1 src0 reset");
    bus_read(3'd1, 8'hFF, "R1 mask0 reset");
    bus_read(3'd2, 8'h00, "R1 src1 reset");
    bus_read(3'd3, 8'hFF, "R1 mask1 reset");
    bus_read(3'd4, 8'h0F, "R1 dma mask reset");

    // R2 layout and R4 clear on read
    pulse0(1, 0, 1);
    bus_read(3'd0, 8'h0A, "R2 rxq+txsent layout");
    bus_read(3'd0, 8'h00, "R4 cleared after read");
    pulse0(0, 1, 0);
    bus_read(3'd0, 8'h04, "R2 drained bit2");

    // R7 event in the read cycle is kept
    pulse0(1, 0, 0);
    @(negedge clk);
    exp_q.push_back(8'h08); tag_q.push_back("R7 read returns old value");
    sel = 1; wr = 0; addr = 3'd0; tx_sent = 1;
    @(negedge clk);
    sel = 0; tx_sent = 0;
    bus_read(3'd0, 8'h02, "R7 colliding event kept");
    bus_read(3'd0, 8'h00, "R4 cleared after second read");

    // R3 second register
    pulse1(5'b10101);
    bus_read(3'd2, 8'h15, "R3 eot+alloc+power");
    pulse1(5'b11111);
    bus_read(3'd2, 8'h1F, "R3 all used bits, top zero");
    bus_read(3'd2, 8'h00, "R4 src1 cleared");

    // R9 map and write behaviour
    bus_write(3'd0, 8'hFF);
    bus_read(3'd0, 8'h00, "R9 write to src0 ignored");
    bus_write(3'd2, 8'hFF);
    bus_read(3'd2, 8'h00, "R9 write to src1 ignored");
    bus_write(3'd3, 8'h3C);
    bus_read(3'd3, 8'h3C, "R9 mask1 readback");
    bus_read(3'd6, 8'h00, "R9 unused address reads zero");

    // R5 masking
    pulse0(0, 0, 1);
    #5; chk_bit(irq0, 1'b0, "R5 masked source no irq0");
    bus_write(3'd1, 8'hFD);
    #5; chk_bit(irq0, 1'b1, "R5 unmasked bit1 raises irq0");
    bus_read(3'd1, 8'hFD, "R9 mask0 readback");
    bus_read(3'd0, 8'h02, "R5 masking kept source");
    #5; chk_bit(irq0, 1'b0, "R5 irq0 drops after clear");
    pulse1(5'b00100);
    #5; chk_bit(irq1, 1'b0, "R5 masked alloc no irq1");
    pulse1(5'b00001);
    #5; chk_bit(irq1, 1'b1, "R5 unmasked power irq1");
    bus_read(3'd2, 8'h05, "R5 src1 keeps masked bit");
    #5; chk_bit(irq1, 1'b0, "R5 irq1 drops after clear");

    // R6 DMA edges
    bus_write(3'd4, 8'h0D);
    bus_read(3'd4, 8'h0D, "R9 dma mask readback");
    @(negedge clk); dma_stat = 4'b0010;
    bus_read(3'd0, 8'h01, "R6 unmasked rise sets summary");
    bus_read(3'd0, 8'h00, "R6 steady level does not reset bit");
    @(negedge clk); dma_stat = 4'b0011;
    bus_read(3'd0, 8'h00, "R6 masked channel ignored");
    @(negedge clk); dma_stat = 4'b0001;
    @(negedge clk); dma_stat = 4'b0011;
    bus_read(3'd0, 8'h01, "R6 new rise after clear");

    // R8 synchronised pin levels
    @(negedge clk); pin_irq = 4'b0100;
    @(negedge clk);
    @(negedge clk);
    bus_read(3'd0, 8'h40, "R8 pin2 after sync");
    bus_read(3'd0, 8'h40, "R8 held pin reasserts");
    @(negedge clk); pin_irq = 4'b0000;
    repeat (4) @(negedge clk);
    bus_read(3'd0, 8'h40, "R8 last latched level");
    bus_read(3'd0, 8'h00, "R8 released pin clears");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule